// File: doc/BRIEF.md
# Converter Command Port over a Two-Wire Serial Bus

This block is the serial front end of a multichannel analog-to-digital converter. It listens as a slave on an I2C bus, clocked entirely by the system clock. SCL and SDA are first resynchronised and then cleaned by a majority vote. The block detects START, repeated START and STOP conditions and compares the 7-bit address of each frame with two addresses. The first is chosen by two three-level address pins. The second is a broadcast address that accepts writes only.

A write frame carries one byte. Its upper six bits become the converter configuration. A read frame returns the latest 12-bit result as two bytes, padded with four zero bits. While the converter core reports that it is busy, the block refuses every address. A STOP after an accepted address asks the core for a new conversion, and so does the completion of a full 16-bit read. A repeated START lets a write be followed by a read without starting a conversion in between.

Top module: `adc_i2c_cmd_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `conv_start_o` and `cfg_o` are all 0.
- R2: Each address pin code is 2'b00 for low, 2'b01 for high and 2'b10 or 2'b11 for floating. Writing (pin1,pin0) as levels, the own address is LL=0x08, LF=0x09, LH=0x0A, FH=0x0B, FF=0x18, FL=0x19, HL=0x1A, HF=0x1B, HH=0x28. A frame to the own address is acknowledged by a pull-down during the ninth SCL pulse.
- R3: An address that is neither the own address nor the broadcast address is not acknowledged (SDA stays released).
- R4: Broadcast address 0x77 is acknowledged with R/W=0 (write) and refused with R/W=1 (read).
- R5: While `busy_i` is 1 at the end of the address byte, no address is acknowledged, and the STOP that follows produces no `conv_start_o` pulse.
- R6: After a write, `cfg_o` equals bits 7:2 of the data byte. The first bit sent is `cfg_o[5]`. Data bits 1:0 have no effect. The byte is acknowledged.
- R7: A read returns 16 bits MSB first: `result_i[11:0]` followed by four 0 bits. SDA changes only after falling SCL edges.
- R8: A STOP after an acknowledged address produces exactly one single-cycle `conv_start_o` pulse.
- R9: Completion of the 16th read bit produces one `conv_start_o` pulse. The STOP that follows produces none.
- R10: A repeated START between a write and a read produces no pulse. The configuration written before it is kept.
- R11: Reads leave `cfg_o` unchanged.
- R12: A STOP when no address was acknowledged since the last STOP produces no pulse.
- R13: If the master does not acknowledge the first read byte, SDA stays released for the rest of the frame, and the following STOP requests a conversion.
- R14: A high pulse on SCL that lasts one clock cycle is ignored. So is a one-cycle SDA pulse while SCL is high: it is neither START nor STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| a1_code | input | 2 | Decoded level of address pin 1 |
| a0_code | input | 2 | Decoded level of address pin 0 |
| busy_i | input | 1 | Converter core is converting |
| result_i | input | RES_W | Latest conversion result |
| cfg_o | output | CFG_W | Configuration word |
| conv_start_o | output | 1 | One-cycle conversion request |

## Verification
The bench builds the block with its defaults: a 12-bit result, a 6-bit configuration and broadcast address 0x77. With these values, all 128 addresses can be swept for one pin setting, and the own address and broadcast address can be tried for each of the nine pin settings. With a six-bit configuration, every configuration value can be written. The bench also reads a walking-one set of results, covers the repeated-START and master-NAK orderings, and injects one-cycle glitches on both lines.

// File: rtl/adc_i2c_cmd_slave.sv
module adc_i2c_cmd_slave #(
  parameter int RES_W = 12,
  parameter int CFG_W = 6,
  parameter logic [6:0] BCAST_ADDR = 7'h77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [1:0]       a1_code,
  input  logic [1:0]       a0_code,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             conv_start_o
);
  localparam int FRAME_W = 16;
  localparam int PAD_W = FRAME_W - RES_W;
  localparam logic [2:0] ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_AACK = 3'd2,
                         ST_WR = 3'd3, ST_WACK = 3'd4, ST_RD = 3'd5, ST_MACK = 3'd6;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  function automatic logic [1:0] lvl(input logic [1:0] c);
    return (c == 2'b00) ? 2'd0 : (c == 2'b01) ? 2'd2 : 2'd1;
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic [2:0] scl_sh, sda_sh;
  logic       scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_sh <= '1; sda_sh <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_sh <= {scl_sh[1:0], scl_sy[1]};
      sda_sh <= {sda_sh[1:0], sda_sy[1]};
      scl_f  <= maj3(scl_sh);
      sda_f  <= maj3(sda_sh);
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire start_c  = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  logic [6:0] own_addr;
  always_comb begin
    case ({lvl(a1_code), lvl(a0_code)})
      4'b0000: own_addr = 7'h08;
      4'b0001: own_addr = 7'h09;
      4'b0010: own_addr = 7'h0A;
      4'b0110: own_addr = 7'h0B;
      4'b0101: own_addr = 7'h18;
      4'b0100: own_addr = 7'h19;
      4'b1000: own_addr = 7'h1A;
      4'b1001: own_addr = 7'h1B;
      default: own_addr = 7'h28;
    endcase
  end

  logic [2:0]         st_q;
  logic [3:0]         cnt_q;
  logic [7:0]         sh_q;
  logic [FRAME_W-1:0] tx_q;
  logic               rw_q, ack_q, mack_q, byte2_q, armed_q, pull_q, go_q;
  logic [CFG_W-1:0]   cfg_q;

  wire addr_hit = !busy_i && ((sh_q[7:1] == own_addr) ||
                              ((sh_q[7:1] == BCAST_ADDR) && !sh_q[0]));
  wire [FRAME_W-1:0] frame = {result_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      rw_q <= 1'b0; ack_q <= 1'b0; mack_q <= 1'b0; byte2_q <= 1'b0;
      armed_q <= 1'b0; pull_q <= 1'b0; go_q <= 1'b0; cfg_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (start_c) begin
        st_q <= ST_ADDR; cnt_q <= '0; pull_q <= 1'b0;
      end else if (stop_c) begin
        st_q <= ST_IDLE; pull_q <= 1'b0;
        go_q <= armed_q; armed_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt_q != 4'd8) begin
              sh_q <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 4'd1;
            end
            if (scl_fall && cnt_q == 4'd8) begin
              if (st_q == ST_ADDR) begin
                rw_q <= sh_q[0]; ack_q <= addr_hit; pull_q <= addr_hit;
                if (addr_hit) armed_q <= 1'b1;
                st_q <= ST_AACK;
              end else begin
                cfg_q <= sh_q[7 -: CFG_W]; pull_q <= 1'b1; st_q <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt_q <= '0;
            if (!ack_q) begin
              st_q <= ST_IDLE; pull_q <= 1'b0;
            end else if (rw_q) begin
              st_q <= ST_RD; tx_q <= frame; pull_q <= ~frame[FRAME_W-1]; byte2_q <= 1'b0;
            end else begin
              st_q <= ST_WR; pull_q <= 1'b0;
            end
          end
          ST_WACK: if (scl_fall) begin
            st_q <= ST_IDLE; pull_q <= 1'b0;
          end
          ST_RD: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall && cnt_q != 4'd0) begin
              tx_q <= tx_q << 1;
              if (cnt_q == 4'd8) begin
                pull_q <= 1'b0; st_q <= ST_MACK;
                if (byte2_q) begin
                  go_q <= 1'b1; armed_q <= 1'b0;
                end
              end else begin
                pull_q <= ~tx_q[FRAME_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_q <= ~sda_f;
            if (scl_fall) begin
              if (mack_q && !byte2_q) begin
                st_q <= ST_RD; byte2_q <= 1'b1; cnt_q <= '0; pull_q <= ~tx_q[FRAME_W-1];
              end else begin
                st_q <= ST_IDLE; pull_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o   = pull_q;
  assign cfg_o        = cfg_q;
  assign conv_start_o = go_q;
endmodule

module adc_i2c_cmd_slave_chk #(
  parameter int CFG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             sda_pull_o,
  input logic             conv_start_o,
  input logic             busy_i,
  input logic [2:0]       st_q,
  input logic [CFG_W-1:0] cfg_o
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_f);

  assert_no_ack_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) && st_q == 3'd2) |-> !$past(busy_i));

  assert_cfg_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> (st_q == 3'd4));

  assert_cfg_kept_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 3'd5) |=> $stable(cfg_o));
endmodule

bind adc_i2c_cmd_slave adc_i2c_cmd_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull_o(sda_pull_o),
  .conv_start_o(conv_start_o), .busy_i(busy_i), .st_q(st_q), .cfg_o(cfg_o)
);

// File: tb/adc_i2c_cmd_slave_tb.sv
`timescale 1ns/1ps
module adc_i2c_cmd_slave_tb_top;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] a1c = 2'b00, a0c = 2'b00;
  logic busy = 1'b0;
  logic [11:0] res = '0;
  logic sda_pull, conv_start;
  logic [5:0] cfg;
  wire sda_line = sda_m & ~sda_pull;
  int tests = 0, fails = 0, pulses = 0;

  always #4 clk = ~clk;

  adc_i2c_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .a1_code(a1c), .a0_code(a0c), .busy_i(busy), .result_i(res), .cfg_o(cfg),
    .conv_start_o(conv_start)
  );

  always @(posedge clk) if (conv_start) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic bit_out(input logic b, input logic g);
    sda_m = b;
    if (g) begin w(2); scl_m = 1'b1; w(1); scl_m = 1'b0; w(Q-3); end
    else w(Q);
    scl_m = 1'b1;
    if (g) begin w(Q); sda_m = ~b; w(1); sda_m = b; w(Q-1); end
    else w(2*Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic g, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i], g);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~mack, 1'b0);
  endtask

  function automatic logic [1:0] code_of(input int l);
    return (l == 0) ? 2'b00 : (l == 2) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [6:0] exp_addr(input int l1, input int l0);
    case (l1 * 3 + l0)
      0: return 7'h08; 1: return 7'h09; 2: return 7'h0A;
      3: return 7'h19; 4: return 7'h18; 5: return 7'h0B;
      6: return 7'h1A; 7: return 7'h1B; default: return 7'h28;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] hi, lo;
    logic [6:0] own;
    int p0;
    w(5); rst_n = 1'b1; w(5);
    chk("R1 pull", sda_pull, 0);
    chk("R1 start", conv_start, 0);
    chk("R1 cfg", cfg, 0);

    // R2 nine pin settings, R4 broadcast, R3/R12 mismatch
    for (int l1 = 0; l1 < 3; l1++) begin
      for (int l0 = 0; l0 < 3; l0++) begin
        a1c = code_of(l1); a0c = code_of(l0);
        own = exp_addr(l1, l0);
        p0 = pulses;
        i2c_start(); send_byte({own, 1'b0}, 1'b0, ack); i2c_stop();
        chk("R2 own ack", ack, 1);
        chk("R8 stop pulse", pulses - p0, 1);
        p0 = pulses;
        i2c_start(); send_byte({own ^ 7'h40, 1'b0}, 1'b0, ack); i2c_stop();
        chk("R3 mismatch nak", ack, 0);
        chk("R12 no pulse", pulses - p0, 0);
        i2c_start(); send_byte({7'h77, 1'b1}, 1'b0, ack); i2c_stop();
        chk("R4 bcast read nak", ack, 0);
      end
    end
    a1c = 2'b11; a0c = 2'b11;
    i2c_start(); send_byte({7'h18, 1'b0}, 1'b0, ack); i2c_stop();
    chk("R2 code 11 float", ack, 1);

    // R2/R3/R4 full address sweep, pins floating
    a1c = 2'b10; a0c = 2'b10;
    for (int a = 0; a < 128; a++) begin
      p0 = pulses;
      i2c_start(); send_byte({a[6:0], 1'b0}, 1'b0, ack); i2c_stop();
      chk("R3 sweep ack", ack, (a == 'h18 || a == 'h77) ? 1 : 0);
      chk("R12 sweep pulse", pulses - p0, (a == 'h18 || a == 'h77) ? 1 : 0);
    end

    // R6 every configuration value, low bits varied
    for (int v = 0; v < 64; v++) begin
      logic [7:0] d;
      d = {v[5:0], v[1:0] ^ v[3:2]};
      i2c_start(); send_byte({7'h18, 1'b0}, 1'b0, ack);
      send_byte(d, 1'b0, ack); i2c_stop();
      chk("R6 data ack", ack, 1);
      chk("R6 cfg", cfg, v);
    end

    // R14 glitches on both lines during a write
    i2c_start(); send_byte({7'h18, 1'b0}, 1'b1, ack);
    chk("R14 addr ack", ack, 1);
    send_byte(8'b1011_0110, 1'b1, ack); i2c_stop();
    chk("R14 cfg", cfg, 6'b101101);

    // R7/R9/R11 reads of walking ones and edge values
    for (int k = 0; k < 16; k++) begin
      res = (k < 12) ? (12'h1 << k) : (k == 12) ? 12'h000 : (k == 13) ? 12'hFFF :
            (k == 14) ? 12'hA5C : 12'h123;
      p0 = pulses;
      i2c_start(); send_byte({7'h18, 1'b1}, 1'b0, ack);
      chk("R7 read ack", ack, 1);
      recv_byte(1'b1, hi); recv_byte(1'b0, lo);
      chk("R7 data", {hi, lo}, {res, 4'b0});
      chk("R9 pulse at end", pulses - p0, 1);
      i2c_stop();
      chk("R9 no pulse at stop", pulses - p0, 1);
      chk("R11 cfg kept", cfg, 6'b101101);
    end

    // R5 busy
    busy = 1'b1; p0 = pulses;
    i2c_start(); send_byte({7'h18, 1'b0}, 1'b0, ack); i2c_stop();
    chk("R5 busy nak", ack, 0);
    chk("R5 busy no pulse", pulses - p0, 0);
    busy = 1'b0;

    // R10 write, repeated start, read
    res = 12'h3C7; p0 = pulses;
    i2c_start(); send_byte({7'h18, 1'b0}, 1'b0, ack);
    send_byte(8'b0100_1011, 1'b0, ack);
    i2c_start();
    chk("R10 no pulse at Sr", pulses - p0, 0);
    send_byte({7'h18, 1'b1}, 1'b0, ack);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo); i2c_stop();
    chk("R10 read data", {hi, lo}, {12'h3C7, 4'b0});
    chk("R10 one pulse", pulses - p0, 1);
    chk("R10 cfg", cfg, 6'b010010);

    // R13 master NAK on the first byte
    res = 12'h000; p0 = pulses;
    i2c_start(); send_byte({7'h18, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, hi);
    chk("R13 first byte", hi, 0);
    recv_byte(1'b0, lo);
    chk("R13 released", lo, 8'hFF);
    chk("R13 no pulse yet", pulses - p0, 0);
    i2c_stop();
    chk("R13 stop pulse", pulses - p0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule